// File: doc/BRIEF.md
# USB Power and Suspend Control Register

This block holds the 8-bit power control and status word of a USB controller that can run as host or as peripheral. A processor reaches it through a single-cycle synchronous port. Some bits are plain processor settings. Others are driven by hardware events: bus reset seen on the wire, entry into suspend, the result of speed negotiation, and the end of a USB reset. Who may write the bus-reset and suspend bits depends on the `host_mode` input. The suspend flag is also cleared as a side effect of an interrupt-register read elsewhere in the controller.

The register bits drive the controller's control outputs directly: line enable, high-speed request, resume drive and the low-power output enable. A small isochronous transmit gate sits beside the register. When the gate is armed, a packet that the transmit logic marks ready is held back until a start-of-frame token arrives. If an IN token comes first, the gate asks for a zero-length packet instead.

Top module: `usb_pwr_ctl`

## Requirements
- R1: After reset, the register reads 0x20: bit 5 (high-speed enable) is 1 and all other bits are 0. `rd_data` reads 0, `hs_request` is 1 and all other outputs are 0.
- R2: A write with `cpu_wr` high at address REG_ADDR loads bits 7, 6, 5, 2 and 0 from `cpu_wdata`. A read with `cpu_rd` high at REG_ADDR returns the register value on `cpu_rdata` one cycle later. A write to any other address has no effect, and a read of any other address returns 0.
- R3: Bit 4 (high-speed mode) ignores processor writes. In peripheral mode (`host_mode`=0) it takes the value of `hs_negotiated` on the cycle that `reset_done` is high.
- R4: In host mode, a processor write that clears bit 3 while bit 3 is 1 loads bit 4 from `hs_negotiated`.
- R5: Bit 3 (bus reset) is written by the processor in host mode. In peripheral mode it follows `bus_reset_det` one cycle later and ignores writes.
- R6: In peripheral mode, bit 1 (suspend) is set by `suspend_entry`. It is cleared by `int_reg_read` or by a register write with bit 2 = 1. Writes to bit 1 itself are ignored.
- R7: In peripheral mode, when `suspend_entry` and a clear event (`int_reg_read` or a write with bit 2 = 1) fall in the same cycle, bit 1 ends up set.
- R8: In host mode, bit 1 is written directly by the processor.
- R9: The outputs follow the register bits:
  - `dp_dm_en` = bit 6 AND peripheral mode.
  - `hs_request` = bit 5.
  - `resume_drive` = bit 2.
  - `suspendm_en` = bit 0.
- R10: The gate is armed when bit 7 = 1, the block is in peripheral mode and `ep_is_iso` = 1. While armed, a `tx_ready` pulse makes a packet pending. The next `sof_token` gives a one-cycle `send_packet` pulse in the following cycle and clears the pending packet.
- R11: While armed and pending, an `in_token` without `sof_token` gives a one-cycle `send_zlp` pulse in the following cycle and clears the pending packet. If `in_token` and `sof_token` arrive in the same cycle, the result is `send_packet`. The gate never pulses both outputs at once.
- R12: While the gate is not armed, `tx_ready` gives `send_packet` in the next cycle and never `send_zlp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host, 0 = peripheral |
| cpu_addr | input | ADDR_W | Processor register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| bus_reset_det | input | 1 | Reset signalling seen on the bus |
| suspend_entry | input | 1 | Pulse: bus went into suspend |
| hs_negotiated | input | 1 | Speed negotiation result, 1 = high speed |
| reset_done | input | 1 | Pulse: USB reset finished (peripheral) |
| int_reg_read | input | 1 | Pulse: interrupt register was read |
| ep_is_iso | input | 1 | Current transmit endpoint is isochronous |
| tx_ready | input | 1 | Pulse: a transmit packet became ready |
| sof_token | input | 1 | Pulse: start-of-frame token received |
| in_token | input | 1 | Pulse: IN token received |
| send_packet | output | 1 | Pulse: send the ready packet |
| send_zlp | output | 1 | Pulse: send a zero-length packet |
| dp_dm_en | output | 1 | Data line driver enable |
| hs_request | output | 1 | Request high-speed during reset negotiation |
| resume_drive | output | 1 | Drive resume signalling |
| suspendm_en | output | 1 | Enable of the low-power output |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the suspend flag's set and clear. The bench raises `suspend_entry` together with `int_reg_read`, and later together with a write that sets the resume bit. Each time it reads the register back and expects bit 1 to still be 1; a separate step then shows that each clear event works alone.

The second pair is the gate's two releases. With a packet pending, the bench pulses `sof_token` and `in_token` in one cycle. It expects exactly one `send_packet` pulse, no `send_zlp`, and a gate that is idle afterwards.

// File: rtl/usb_pwr_ctl.sv
module usb_pwr_ctl #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  input  logic              bus_reset_det,
  input  logic              suspend_entry,
  input  logic              hs_negotiated,
  input  logic              reset_done,
  input  logic              int_reg_read,
  input  logic              ep_is_iso,
  input  logic              tx_ready,
  input  logic              sof_token,
  input  logic              in_token,
  output logic              send_packet,
  output logic              send_zlp,
  output logic              dp_dm_en,
  output logic              hs_request,
  output logic              resume_drive,
  output logic              suspendm_en
);
  localparam int B_ISO  = 7;
  localparam int B_CONN = 6;
  localparam int B_HSEN = 5;
  localparam int B_HSM  = 4;
  localparam int B_RST  = 3;
  localparam int B_RES  = 2;
  localparam int B_SUSP = 1;
  localparam int B_SMEN = 0;
  localparam logic [7:0] RESET_VAL = 8'h1 << B_HSEN;

  logic [7:0] pwr;
  logic       pending;

  wire sel        = (cpu_addr == REG_ADDR);
  wire wr         = cpu_wr & sel;
  wire periph     = ~host_mode;
  wire resume_set = wr & cpu_wdata[B_RES];
  wire host_rst_clr = host_mode & wr & pwr[B_RST] & ~cpu_wdata[B_RST];
  wire gate_on    = periph & pwr[B_ISO] & ep_is_iso;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr <= RESET_VAL;
    end else begin
      if (wr) begin
        pwr[B_ISO]  <= cpu_wdata[B_ISO];
        pwr[B_CONN] <= cpu_wdata[B_CONN];
        pwr[B_HSEN] <= cpu_wdata[B_HSEN];
        pwr[B_RES]  <= cpu_wdata[B_RES];
        pwr[B_SMEN] <= cpu_wdata[B_SMEN];
      end

      if (periph)       pwr[B_RST] <= bus_reset_det;
      else if (wr)      pwr[B_RST] <= cpu_wdata[B_RST];

      if (periph && reset_done) pwr[B_HSM] <= hs_negotiated;
      else if (host_rst_clr)    pwr[B_HSM] <= hs_negotiated;

      if (periph) begin
        if (suspend_entry)                   pwr[B_SUSP] <= 1'b1;
        else if (int_reg_read || resume_set) pwr[B_SUSP] <= 1'b0;
      end else if (wr) begin
        pwr[B_SUSP] <= cpu_wdata[B_SUSP];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_rdata <= '0;
    else        cpu_rdata <= (cpu_rd && sel) ? pwr : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      send_packet <= 1'b0;
      send_zlp    <= 1'b0;
    end else begin
      if (!gate_on)                              pending <= 1'b0;
      else if (pending && (sof_token || in_token)) pending <= 1'b0;
      else if (tx_ready)                         pending <= 1'b1;
      send_packet <= gate_on ? (pending & sof_token) : tx_ready;
      send_zlp    <= gate_on & pending & in_token & ~sof_token;
    end
  end

  assign dp_dm_en     = pwr[B_CONN] & periph;
  assign hs_request   = pwr[B_HSEN];
  assign resume_drive = pwr[B_RES];
  assign suspendm_en  = pwr[B_SMEN];
endmodule

// File: rtl/usb_pwr_ctl_chk.sv
module usb_pwr_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_mode,
  input logic       bus_reset_det,
  input logic       suspend_entry,
  input logic       reset_done,
  input logic       cpu_wr,
  input logic       tx_ready,
  input logic       sof_token,
  input logic       in_token,
  input logic [7:0] pwr,
  input logic       send_packet,
  input logic       send_zlp
);
  AST_ONE_SEND_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(send_packet && send_zlp)); // R11

  AST_ZLP_AFTER_IN: assert property (@(posedge clk) disable iff (!rst_n)
    send_zlp |-> $past(in_token)); // R11

  AST_PKT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    send_packet |-> ($past(sof_token) || $past(tx_ready))); // R10

  AST_SUSP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(host_mode) && $past(suspend_entry)) |-> pwr[1]); // R7

  AST_BUSRST_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(host_mode)) |-> (pwr[3] == $past(bus_reset_det))); // R5

  AST_HSMODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(reset_done) && !$past(cpu_wr)) |-> (pwr[4] == $past(pwr[4]))); // R3
endmodule

bind usb_pwr_ctl usb_pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .bus_reset_det(bus_reset_det),
  .suspend_entry(suspend_entry), .reset_done(reset_done), .cpu_wr(cpu_wr),
  .tx_ready(tx_ready), .sof_token(sof_token), .in_token(in_token), .pwr(pwr),
  .send_packet(send_packet), .send_zlp(send_zlp)
);

// File: tb/tb_usb_pwr_ctl.sv
module tb_usb_pwr_ctl;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] RA = 'h1;

  logic clk = 0, rst_n = 0, host_mode = 0;
  logic [ADDR_W-1:0] cpu_addr = RA;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic bus_reset_det = 0, suspend_entry = 0, hs_negotiated = 0, reset_done = 0;
  logic int_reg_read = 0, ep_is_iso = 0, tx_ready = 0, sof_token = 0, in_token = 0;
  logic send_packet, send_zlp, dp_dm_en, hs_request, resume_drive, suspendm_en;
  int checks = 0, errors = 0;
  bit done = 0;

  usb_pwr_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) dut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    step(); cpu_wr = 0; cpu_addr = RA;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d);
    cpu_addr = a; cpu_rd = 1;
    step(); d = cpu_rdata; cpu_rd = 0; cpu_addr = RA;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 rdata", cpu_rdata, 8'h00);
    chk("R1 outs", {dp_dm_en, hs_request, resume_drive, suspendm_en, send_packet, send_zlp}, 8'h10);
    rd(RA, v); chk("R1 value", v, 8'h20);
  endtask

  task automatic t_rw();
    logic [7:0] v;
    wr(RA, 8'hFF); rd(RA, v);
    chk("R2 rw bits", v & 8'hE5, 8'hE5);
    chk("R2 ro bits periph", v & 8'h1A, 8'h00);
    wr(RA, 8'h20);
    wr(RA + 1, 8'hC5); rd(RA, v); chk("R2 other addr write", v, 8'h20);
    rd(RA + 1, v); chk("R2 other addr read", v, 8'h00);
  endtask

  task automatic t_hs_periph();
    logic [7:0] v;
    hs_negotiated = 1; step(); rd(RA, v); chk("R3 no event", v[4], 0);
    reset_done = 1; step(); reset_done = 0; hs_negotiated = 0;
    rd(RA, v); chk("R3 captured", v[4], 1);
    wr(RA, 8'h20); rd(RA, v); chk("R3 write ignored", v[4], 1);
  endtask

  task automatic t_hs_host();
    logic [7:0] v;
    host_mode = 1; hs_negotiated = 0;
    wr(RA, 8'h28); rd(RA, v); chk("R5 host write rst", v[3], 1);
    chk("R4 held while set", v[4], 1);
    wr(RA, 8'h20); rd(RA, v); chk("R4 captured on clear", v[4:3], 2'b00);
    host_mode = 0;
  endtask

  task automatic t_busrst();
    logic [7:0] v;
    bus_reset_det = 1; step(); rd(RA, v); chk("R5 follows det", v[3], 1);
    bus_reset_det = 0; wr(RA, 8'h28); rd(RA, v); chk("R5 write ignored periph", v[3], 0);
  endtask

  task automatic t_susp_periph();
    logic [7:0] v;
    wr(RA, 8'h22); rd(RA, v); chk("R6 write ignored", v[1], 0);
    suspend_entry = 1; step(); suspend_entry = 0;
    rd(RA, v); chk("R6 set", v[1], 1);
    int_reg_read = 1; step(); int_reg_read = 0;
    rd(RA, v); chk("R6 int read clears", v[1], 0);
    suspend_entry = 1; step(); suspend_entry = 0;
    wr(RA, 8'h24); rd(RA, v); chk("R6 resume clears", v[2:1], 2'b10);
    wr(RA, 8'h20);
  endtask

  task automatic t_susp_race();
    logic [7:0] v;
    suspend_entry = 1; int_reg_read = 1; step(); suspend_entry = 0; int_reg_read = 0;
    rd(RA, v); chk("R7 set beats int read", v[1], 1);
    int_reg_read = 1; step(); int_reg_read = 0;
    suspend_entry = 1; cpu_wdata = 8'h24; cpu_wr = 1; step();
    suspend_entry = 0; cpu_wr = 0;
    rd(RA, v); chk("R7 set beats resume", v[1], 1);
    int_reg_read = 1; step(); int_reg_read = 0; wr(RA, 8'h20);
  endtask

  task automatic t_susp_host();
    logic [7:0] v;
    host_mode = 1;
    wr(RA, 8'h22); rd(RA, v); chk("R8 host set", v[1], 1);
    suspend_entry = 1; wr(RA, 8'h20); suspend_entry = 0;
    rd(RA, v); chk("R8 host clear", v[1], 0);
    host_mode = 0;
  endtask

  task automatic t_outputs();
    wr(RA, 8'h65);
    chk("R9 periph outs", {dp_dm_en, hs_request, resume_drive, suspendm_en}, 8'h0F);
    host_mode = 1; #1;
    chk("R9 host line off", dp_dm_en, 0);
    host_mode = 0; wr(RA, 8'h00);
    chk("R9 cleared", {dp_dm_en, hs_request, resume_drive, suspendm_en}, 8'h00);
  endtask

  task automatic t_iso_sof();
    wr(RA, 8'hA0); ep_is_iso = 1;
    tx_ready = 1; step(); tx_ready = 0;
    chk("R10 held", {send_packet, send_zlp}, 0);
    step(); step(); chk("R10 still held", {send_packet, send_zlp}, 0);
    sof_token = 1; step(); sof_token = 0;
    chk("R10 sent after sof", {send_packet, send_zlp}, 2'b10);
    step(); chk("R10 one cycle", {send_packet, send_zlp}, 0);
    sof_token = 1; step(); sof_token = 0;
    chk("R10 idle sof", {send_packet, send_zlp}, 0);
  endtask

  task automatic t_iso_zlp();
    tx_ready = 1; step(); tx_ready = 0;
    in_token = 1; step(); in_token = 0;
    chk("R11 zlp", {send_packet, send_zlp}, 2'b01);
    sof_token = 1; step(); sof_token = 0;
    chk("R11 cleared after zlp", {send_packet, send_zlp}, 0);
    tx_ready = 1; step(); tx_ready = 0;
    sof_token = 1; in_token = 1; step(); sof_token = 0; in_token = 0;
    chk("R11 same cycle", {send_packet, send_zlp}, 2'b10);
    in_token = 1; step(); in_token = 0;
    chk("R11 idle after", {send_packet, send_zlp}, 0);
  endtask

  task automatic t_bypass();
    ep_is_iso = 0;
    tx_ready = 1; step(); tx_ready = 0;
    chk("R12 non-iso ep", {send_packet, send_zlp}, 2'b10);
    ep_is_iso = 1; wr(RA, 8'h20);
    tx_ready = 1; in_token = 1; step(); tx_ready = 0; in_token = 0;
    chk("R12 iso update off", {send_packet, send_zlp}, 2'b10);
    wr(RA, 8'hA0); host_mode = 1;
    tx_ready = 1; step(); tx_ready = 0;
    chk("R12 host mode", {send_packet, send_zlp}, 2'b10);
    host_mode = 0; ep_is_iso = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_rw();
    t_hs_periph();
    t_hs_host();
    t_busrst();
    t_susp_periph();
    t_susp_race();
    t_susp_host();
    t_outputs();
    t_iso_sof();
    t_iso_zlp();
    t_bypass();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule